// File: doc/BRIEF.md
# Display Refill FIFO with Watermark-Priority Memory Requests

This block sits between a memory controller and a display pixel path. Display words arrive from memory in bursts and are queued in a 64-entry, 64-bit-wide FIFO. Each entry carries a one-bit tag that says whether the word is pixel data or cursor pattern data. The display side pops words in order and receives the tag with each word.

The block watches its own fill level and asks the memory arbiter for refill at one of two levels. When the level is below a programmable low watermark, it raises an urgent request. When the level is at or above the watermark but the FIFO is not full, it raises a background request. A full FIFO raises neither request.

A small arbiter model is included. An urgent display request beats the CPU-cache and graphics requesters. Those requesters in turn preempt a background display refill, so background bursts are only serviced when nothing else is waiting.

Top module: `dfq_top`

## Requirements
- R1: While `rst` is high, and on the first clock edge with it high, the block clears its state: `level` is 0, `underflow` is 0, `rd_valid` is 0, both requests are 0 and all three grants are 0.
- R2: Words leave the FIFO in the order they were written, each with its own tag (`wr_cursor`/`rd_cursor` = 1 for cursor pattern data, 0 for pixel data). A read accepted at a clock edge presents its word on `rd_data`/`rd_cursor` with `rd_valid` high after that edge, for one cycle.
- R3: A write while `level` is 64 is dropped. `level` never exceeds 64, and the dropped word never appears on the read side.
- R4: A read while `level` is 0 is refused: `rd_valid` stays 0 and `level` stays 0. It also sets `underflow`, which then stays at 1 until reset.
- R5: `req_urgent` is 1 exactly when `level` is strictly less than the 6-bit `thresh` and `level` is not 64. A changed `thresh` takes effect one cycle later.
- R6: `req_bg` is 1 exactly when `level` is at or above `thresh` and below 64. It is never 1 together with `req_urgent`.
- R7: When `level` is 64, both `req_urgent` and `req_bg` are 0.
- R8: At most one of `gnt_disp`, `gnt_cpu` and `gnt_gfx` is 1. The grants are registered: the grant after an edge is decided from the requests present before it.
- R9: While `req_urgent` is 1, the next grant is `gnt_disp`, whatever `cpu_req` and `gfx_req` are.
- R10: Without an urgent request, the next grant goes in this order of priority: `cpu_req` first, then `gfx_req`, then a background display refill (`req_bg`). With no requests, no grant is issued.
- R11: A write and a read in the same cycle on a non-empty, non-full FIFO leave `level` unchanged and return the oldest word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one word from memory |
| wr_data | input | 64 | Word to queue |
| wr_cursor | input | 1 | Tag of the written word: 1 = cursor, 0 = pixel |
| rd_en | input | 1 | Pop request from the display path |
| rd_data | output | 64 | Popped word |
| rd_cursor | output | 1 | Tag of the popped word |
| rd_valid | output | 1 | `rd_data`/`rd_cursor` hold a popped word this cycle |
| thresh | input | 6 | Low watermark for urgent requests |
| cpu_req | input | 1 | CPU-cache memory request |
| gfx_req | input | 1 | Graphics memory request |
| req_urgent | output | 1 | Display urgent refill request |
| req_bg | output | 1 | Display background refill request |
| gnt_disp | output | 1 | Memory granted to display refill |
| gnt_cpu | output | 1 | Memory granted to CPU-cache |
| gnt_gfx | output | 1 | Memory granted to graphics |
| level | output | 7 | Current FIFO occupancy, 0 to 64 |
| underflow | output | 1 | Sticky flag: a read was attempted while empty |

## Verification
The bench walks the watermark edge from both sides, with `level` one below, equal to and one above `thresh`. A design that compares with less-or-equal would report urgent at the boundary level. It sets `thresh` to 0, where urgent must never rise, and fills the FIFO to exactly 64, where both requests must drop. It then writes once more: a design that wraps its pointers on that write would corrupt the oldest word or report a level of 0. It reads while empty, checks that `underflow` survives a later write, and confirms that no stale word is flagged valid. It also drives every combination of CPU, graphics and display requests. A design with the wrong priority order would grant the CPU ahead of an urgent display request, or grant a background refill while other traffic is waiting.

// File: rtl/dfq_pkg.sv
package dfq_pkg;

  // One-hot grant vector of the arbiter model
  typedef struct packed {
    logic gfx;
    logic cpu;
    logic disp;
  } dfq_gnt_t;

  localparam dfq_gnt_t GNT_NONE = '{gfx: 1'b0, cpu: 1'b0, disp: 1'b0};

endpackage

// File: rtl/dfq_mem.sv
// Simple dual-port storage with registered read, shaped for block RAM.
module dfq_mem #(
  parameter int WW    = 65,
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [WW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [WW-1:0] rdata
);

  logic [WW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= store[raddr];
  end

endmodule

// File: rtl/dfq_ctrl.sv
// Pointer, occupancy and watermark request logic.
module dfq_ctrl #(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int CW    = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] thresh,
  output logic          do_wr,
  output logic          do_rd,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic [CW-1:0] level,
  output logic          req_urgent,
  output logic          req_bg,
  output logic          rd_valid,
  output logic          underflow
);

  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic          is_full, is_empty;
  logic [CW-1:0] level_nxt;
  logic          full_nxt, urg_nxt;

  assign is_full  = (level == FULL_LVL);
  assign is_empty = (level == '0);
  assign do_wr    = wr_en && !is_full;
  assign do_rd    = rd_en && !is_empty;

  always_comb begin
    level_nxt = level;
    if (do_wr && !do_rd) level_nxt = level + 1'b1;
    else if (do_rd && !do_wr) level_nxt = level - 1'b1;
  end

  assign full_nxt = (level_nxt == FULL_LVL);
  assign urg_nxt  = !full_nxt && (level_nxt < {1'b0, thresh});

  always_ff @(posedge clk) begin
    if (rst) begin
      waddr      <= '0;
      raddr      <= '0;
      level      <= '0;
      req_urgent <= 1'b0;
      req_bg     <= 1'b0;
      rd_valid   <= 1'b0;
      underflow  <= 1'b0;
    end else begin
      if (do_wr) waddr <= (waddr == LAST_IDX) ? '0 : waddr + 1'b1;
      if (do_rd) raddr <= (raddr == LAST_IDX) ? '0 : raddr + 1'b1;
      level      <= level_nxt;
      req_urgent <= urg_nxt;
      req_bg     <= !full_nxt && !urg_nxt;
      rd_valid   <= do_rd;
      if (rd_en && is_empty) underflow <= 1'b1;
    end
  end

endmodule

// File: rtl/dfq_arb.sv
// Arbiter model: urgent display > cpu > gfx > background display.
module dfq_arb
  import dfq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     req_urgent,
  input  logic     req_bg,
  input  logic     cpu_req,
  input  logic     gfx_req,
  output dfq_gnt_t gnt
);

  dfq_gnt_t gnt_nxt;

  always_comb begin
    gnt_nxt = GNT_NONE;
    if (req_urgent)   gnt_nxt.disp = 1'b1;
    else if (cpu_req) gnt_nxt.cpu  = 1'b1;
    else if (gfx_req) gnt_nxt.gfx  = 1'b1;
    else if (req_bg)  gnt_nxt.disp = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) gnt <= GNT_NONE;
    else     gnt <= gnt_nxt;
  end

endmodule

// File: rtl/dfq_top.sv
module dfq_top
  import dfq_pkg::*;
#(
  parameter int DW    = 64,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_cursor,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_cursor,
  output logic          rd_valid,
  input  logic [AW-1:0] thresh,
  input  logic          cpu_req,
  input  logic          gfx_req,
  output logic          req_urgent,
  output logic          req_bg,
  output logic          gnt_disp,
  output logic          gnt_cpu,
  output logic          gnt_gfx,
  output logic [CW-1:0] level,
  output logic          underflow
);

  localparam int WW = DW + 1;

  logic          do_wr, do_rd;
  logic [AW-1:0] waddr, raddr;
  logic [WW-1:0] mem_q;
  dfq_gnt_t      gnt;

  dfq_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .thresh     (thresh),
    .do_wr      (do_wr),
    .do_rd      (do_rd),
    .waddr      (waddr),
    .raddr      (raddr),
    .level      (level),
    .req_urgent (req_urgent),
    .req_bg     (req_bg),
    .rd_valid   (rd_valid),
    .underflow  (underflow)
  );

  dfq_mem #(.WW(WW), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk   (clk),
    .we    (do_wr),
    .waddr (waddr),
    .wdata ({wr_cursor, wr_data}),
    .re    (do_rd),
    .raddr (raddr),
    .rdata (mem_q)
  );

  dfq_arb u_arb (
    .clk        (clk),
    .rst        (rst),
    .req_urgent (req_urgent),
    .req_bg     (req_bg),
    .cpu_req    (cpu_req),
    .gfx_req    (gfx_req),
    .gnt        (gnt)
  );

  assign rd_data   = mem_q[DW-1:0];
  assign rd_cursor = mem_q[DW];
  assign gnt_disp  = gnt.disp;
  assign gnt_cpu   = gnt.cpu;
  assign gnt_gfx   = gnt.gfx;

endmodule

// File: rtl/dfq_chk.sv
module dfq_chk #(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int CW    = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          rd_en,
  input logic          rd_valid,
  input logic [AW-1:0] thresh,
  input logic          cpu_req,
  input logic          gfx_req,
  input logic          req_urgent,
  input logic          req_bg,
  input logic          gnt_disp,
  input logic          gnt_cpu,
  input logic          gnt_gfx,
  input logic [CW-1:0] level,
  input logic          underflow
);

  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (level == '0 && !underflow && !rd_valid && !req_urgent && !req_bg
             && !gnt_disp && !gnt_cpu && !gnt_gfx));

  p_rdvalid_cause_r2: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    level <= FULL_LVL);

  p_uf_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    underflow |=> underflow);

  p_urg_below_r5: assert property (@(posedge clk) disable iff (rst)
    req_urgent |-> (level < {1'b0, $past(thresh)}));

  p_req_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(req_urgent && req_bg));

  p_full_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (level == FULL_LVL) |-> (!req_urgent && !req_bg));

  p_gnt_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({gnt_disp, gnt_cpu, gnt_gfx}));

  p_urg_wins_r9: assert property (@(posedge clk) disable iff (rst)
    req_urgent |=> gnt_disp);

  p_cpu_first_r10: assert property (@(posedge clk) disable iff (rst)
    (!req_urgent && cpu_req) |=> gnt_cpu);

endmodule

bind dfq_top dfq_chk #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rd_en      (rd_en),
  .rd_valid   (rd_valid),
  .thresh     (thresh),
  .cpu_req    (cpu_req),
  .gfx_req    (gfx_req),
  .req_urgent (req_urgent),
  .req_bg     (req_bg),
  .gnt_disp   (gnt_disp),
  .gnt_cpu    (gnt_cpu),
  .gnt_gfx    (gnt_gfx),
  .level      (level),
  .underflow  (underflow)
);

// File: tb/dfq_top_test.sv
module dfq_top_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, wr_cursor = 1'b0, rd_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic [5:0]  thresh = 6'd8;
  logic        cpu_req = 1'b0, gfx_req = 1'b0;
  logic [63:0] rd_data;
  logic        rd_cursor, rd_valid, req_urgent, req_bg;
  logic        gnt_disp, gnt_cpu, gnt_gfx, underflow;
  logic [6:0]  level;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dfq_top uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_cursor(wr_cursor),
    .rd_en(rd_en), .rd_data(rd_data), .rd_cursor(rd_cursor), .rd_valid(rd_valid),
    .thresh(thresh), .cpu_req(cpu_req), .gfx_req(gfx_req),
    .req_urgent(req_urgent), .req_bg(req_bg), .gnt_disp(gnt_disp),
    .gnt_cpu(gnt_cpu), .gnt_gfx(gnt_gfx), .level(level), .underflow(underflow)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(input int i);
    return {32'hC0DE_0000 + 32'(i), 32'(i) ^ 32'h5A5A_5A5A};
  endfunction

  task automatic do_reset();
    rst = 1'b1; wr_en = 0; rd_en = 0; cpu_req = 0; gfx_req = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic push(input logic [63:0] d, input logic t);
    wr_en = 1; wr_data = d; wr_cursor = t;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pop_expect(input logic [63:0] d, input logic t, input string tag);
    rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    chk(rd_valid === 1'b1, {tag, " rd_valid"}, 64'(rd_valid), 64'd1);
    chk(rd_data === d, {tag, " rd_data"}, rd_data, d);
    chk(rd_cursor === t, {tag, " rd_cursor"}, 64'(rd_cursor), 64'(t));
  endtask

  task automatic t_reset_r1();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(level === 0 && underflow === 0 && rd_valid === 0, "R1 state clear",
        {level, underflow, rd_valid}, 64'd0);
    chk({req_urgent, req_bg, gnt_disp, gnt_cpu, gnt_gfx} === 5'b0, "R1 req/gnt clear",
        64'({req_urgent, req_bg, gnt_disp, gnt_cpu, gnt_gfx}), 64'd0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_order_r2();
    do_reset();
    for (int i = 0; i < 6; i++) push(pat(i), logic'(i % 3 == 1));
    chk(level === 7'd6, "R2 level after 6 writes", 64'(level), 64'd6);
    for (int i = 0; i < 6; i++) pop_expect(pat(i), logic'(i % 3 == 1), "R2 order");
    @(negedge clk);
    chk(rd_valid === 0, "R2 rd_valid one cycle", 64'(rd_valid), 64'd0);
    chk(level === 0, "R2 level drained", 64'(level), 64'd0);
  endtask

  task automatic t_simul_r11();
    do_reset();
    for (int i = 0; i < 3; i++) push(pat(10 + i), 1'b0);
    wr_en = 1; wr_data = pat(20); wr_cursor = 1; rd_en = 1;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    chk(level === 7'd3, "R11 level unchanged", 64'(level), 64'd3);
    chk(rd_valid === 1 && rd_data === pat(10), "R11 oldest word", rd_data, pat(10));
    pop_expect(pat(11), 1'b0, "R11 next");
    pop_expect(pat(12), 1'b0, "R11 next");
    pop_expect(pat(20), 1'b1, "R11 written word");
  endtask

  task automatic t_full_r3_r7();
    do_reset();
    thresh = 6'd8;
    for (int i = 0; i < 64; i++) push(pat(100 + i), logic'(i[0]));
    chk(level === 7'd64, "R3 level at full", 64'(level), 64'd64);
    chk(req_urgent === 0 && req_bg === 0, "R7 full suppresses requests",
        64'({req_urgent, req_bg}), 64'd0);
    push(64'hDEAD_BEEF_DEAD_BEEF, 1'b1);
    chk(level === 7'd64, "R3 write on full dropped", 64'(level), 64'd64);
    pop_expect(pat(100), 1'b0, "R3 oldest intact");
    chk(req_bg === 1 && req_urgent === 0, "R6 bg after leaving full",
        64'({req_urgent, req_bg}), 64'b01);
    for (int i = 1; i < 64; i++) pop_expect(pat(100 + i), logic'(i % 2), "R3 drain");
    chk(level === 0, "R3 dropped word absent", 64'(level), 64'd0);
  endtask

  task automatic t_underflow_r4();
    do_reset();
    chk(underflow === 0, "R4 clear before", 64'(underflow), 64'd0);
    rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    chk(rd_valid === 0, "R4 no valid on empty", 64'(rd_valid), 64'd0);
    chk(level === 0, "R4 level stays 0", 64'(level), 64'd0);
    chk(underflow === 1, "R4 underflow set", 64'(underflow), 64'd1);
    push(pat(7), 1'b0);
    chk(underflow === 1, "R4 underflow sticky", 64'(underflow), 64'd1);
    chk(level === 1, "R4 level after write", 64'(level), 64'd1);
    do_reset();
    chk(underflow === 0, "R4 cleared by reset", 64'(underflow), 64'd0);
  endtask

  task automatic t_watermark_r5_r6();
    thresh = 6'd8;
    do_reset();
    chk(req_urgent === 1 && req_bg === 0, "R5 empty below thresh", 64'({req_urgent, req_bg}), 64'b10);
    for (int i = 0; i < 7; i++) push(pat(i), 1'b0);
    chk(req_urgent === 1 && req_bg === 0, "R5 level 7 < 8 urgent", 64'({req_urgent, req_bg}), 64'b10);
    push(pat(7), 1'b0);
    chk(req_urgent === 0 && req_bg === 1, "R6 level 8 == thresh bg", 64'({req_urgent, req_bg}), 64'b01);
    push(pat(8), 1'b0);
    chk(req_urgent === 0 && req_bg === 1, "R6 level 9 bg", 64'({req_urgent, req_bg}), 64'b01);
    pop_expect(pat(0), 1'b0, "R5 pop");
    pop_expect(pat(1), 1'b0, "R5 pop");
    chk(req_urgent === 1 && req_bg === 0, "R5 back below thresh", 64'({req_urgent, req_bg}), 64'b10);
    thresh = 6'd0;
    @(negedge clk);
    chk(req_urgent === 0 && req_bg === 1, "R5 thresh 0 never urgent", 64'({req_urgent, req_bg}), 64'b01);
    thresh = 6'd63;
    @(negedge clk);
    chk(req_urgent === 1, "R5 thresh 63 urgent", 64'(req_urgent), 64'd1);
    thresh = 6'd8;
  endtask

  task automatic t_arb_r8_r9_r10();
    thresh = 6'd8;
    do_reset();
    cpu_req = 1; gfx_req = 1;
    @(negedge clk);
    chk({gnt_disp, gnt_cpu, gnt_gfx} === 3'b100, "R9 urgent beats cpu/gfx",
        64'({gnt_disp, gnt_cpu, gnt_gfx}), 64'b100);
    cpu_req = 0; gfx_req = 0;
    for (int i = 0; i < 10; i++) push(pat(i), 1'b0);
    cpu_req = 1; gfx_req = 1;
    @(negedge clk);
    chk({gnt_disp, gnt_cpu, gnt_gfx} === 3'b010, "R10 cpu before gfx and bg",
        64'({gnt_disp, gnt_cpu, gnt_gfx}), 64'b010);
    cpu_req = 0;
    @(negedge clk);
    chk({gnt_disp, gnt_cpu, gnt_gfx} === 3'b001, "R10 gfx before bg",
        64'({gnt_disp, gnt_cpu, gnt_gfx}), 64'b001);
    gfx_req = 0;
    @(negedge clk);
    chk({gnt_disp, gnt_cpu, gnt_gfx} === 3'b100, "R10 bg when idle",
        64'({gnt_disp, gnt_cpu, gnt_gfx}), 64'b100);
    for (int i = 10; i < 64; i++) push(pat(i), 1'b0);
    @(negedge clk);
    chk({gnt_disp, gnt_cpu, gnt_gfx} === 3'b000, "R8 no grant when full and idle",
        64'({gnt_disp, gnt_cpu, gnt_gfx}), 64'b000);
    gfx_req = 1;
    @(negedge clk);
    chk({gnt_disp, gnt_cpu, gnt_gfx} === 3'b001, "R8 single grant gfx",
        64'({gnt_disp, gnt_cpu, gnt_gfx}), 64'b001);
    gfx_req = 0;
  endtask

  initial begin
    t_reset_r1();
    t_order_r2();
    t_simul_r11();
    t_full_r3_r7();
    t_underflow_r4();
    t_watermark_r5_r6();
    t_arb_r8_r9_r10();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule